// File: doc/BRIEF.md
# Load-Align Shift-Merge Unit

This unit builds a 64-bit value one memory element at a time. Each accepted load pushes a new element into the top of the value and pushes the same amount of old content out of the bottom. After several loads the value holds the most recent elements, the newest at the top, much like a small queue of memory elements.

The caller supplies the current destination value and the raw load data, together with an element-size select and a valid strobe. On a clock edge with the strobe high, the registered result becomes the old value shifted toward bit 0 by the element width, with the new element placed in the highest bits. To chain loads, the caller feeds the result back as the next old value. Address generation, the memory access itself and any extension of the element are left to the surrounding logic.

Top module: `load_align_merge`

## Requirements
- R1: A synchronous reset sets `dst_new` to zero by the next clock edge, and the reset takes priority over a pending load.
- R2: While `ld_valid` is low, `dst_new` keeps its value on every edge, whatever `dst_old`, `ld_data` and `ld_size` do.
- R3: Byte mode (`ld_size` = 0). One cycle after an accepted load, `dst_new` equals `{ld_data[7:0], dst_old[63:8]}`.
- R4: Halfword mode (`ld_size` = 1). One cycle after an accepted load, `dst_new` equals `{ld_data[15:0], dst_old[63:16]}`.
- R5: In byte mode, `ld_data[15:8]` has no effect on the result.
- R6: The data is little-endian. `ld_data[7:0]` is the byte at the lower address, so in halfword mode it lands in bits 55:48 and the higher-address byte lands in bits 63:56.
- R7: Start from all ones and chain four byte loads of 0x01, 0x02, 0x03 and 0x04. The result is 0x04030201ffffffff.
- R8: Start from all ones and chain four halfword loads of consecutive byte pairs 01 02 through 07 08. The result is 0x0807060504030201.
- R9: Bits shifted past bit 0 are lost. The element is inserted as raw bits, with no sign or zero extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | Accept a load on this edge |
| ld_size | input | 1 | Element size: 0 byte, 1 halfword |
| ld_data | input | 16 | Raw load data, lower-address byte in bits 7:0 |
| dst_old | input | 64 | Current destination value to merge into |
| dst_new | output | 64 | Registered merged value |

## Verification
The only state is the result register. If it were wrong, the error would show on `dst_new` one cycle after the load that caused it, or as drift on an idle cycle. A wrong shift amount or wrong lane order shows as misplaced bytes in that same sample. The chained sequences feed each result back as the next input, so an error in one step carries through to every later value of the chain.

// File: rtl/lam_pkg.sv
package lam_pkg;
    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_HALF = 1'b1
    } elem_size_e;

    localparam int LAM_DST_W = 64;

    typedef struct packed {
        logic [LAM_DST_W-1:0] dst;
    } lam_state_t;
endpackage

// File: rtl/lam_size_decode.sv
module lam_size_decode
    import lam_pkg::*;
#(
    parameter int MAX_LANES = 2
) (
    input  elem_size_e           size_i,
    output logic [MAX_LANES-1:0] sel_o
);
    localparam int IDX_W = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1;

    logic [IDX_W-1:0] lane_idx;

    always_comb begin
        // halfword uses two lanes (index 1), byte uses one (index 0)
        lane_idx = (size_i == SZ_HALF) ? IDX_W'(1) : IDX_W'(0);
        sel_o    = '0;
        sel_o[lane_idx] = 1'b1;
    end
endmodule

// File: rtl/lam_shift_merge.sv
module lam_shift_merge #(
    parameter int DST_W     = 64,
    parameter int LANE_W    = 8,
    parameter int MAX_LANES = 2,
    localparam int SRC_W    = LANE_W * MAX_LANES
) (
    input  logic [DST_W-1:0]     old_i,
    input  logic [SRC_W-1:0]     src_i,
    input  logic [MAX_LANES-1:0] sel_i,
    output logic [DST_W-1:0]     merged_o
);
    logic [DST_W-1:0] cand [MAX_LANES];

    // one candidate per element width: new lanes on top, old shifted down
    for (genvar n = 1; n <= MAX_LANES; n++) begin : g_cand
        localparam int KW = n * LANE_W;
        assign cand[n-1] = {src_i[KW-1:0], old_i[DST_W-1:KW]};
    end

    always_comb begin
        merged_o = '0;
        for (int k = 0; k < MAX_LANES; k++) begin
            if (sel_i[k]) merged_o = merged_o | cand[k];
        end
    end
endmodule

// File: rtl/load_align_merge.sv
module load_align_merge
    import lam_pkg::*;
#(
    parameter int DST_W     = 64,
    parameter int LANE_W    = 8,
    parameter int MAX_LANES = 2,
    localparam int SRC_W    = LANE_W * MAX_LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_valid,
    input  logic             ld_size,
    input  logic [SRC_W-1:0] ld_data,
    input  logic [DST_W-1:0] dst_old,
    output logic [DST_W-1:0] dst_new
);
    elem_size_e           size_sel;
    logic [MAX_LANES-1:0] lane_sel;
    logic [DST_W-1:0]     merged;
    lam_state_t           st_d, st_q;

    assign size_sel = elem_size_e'(ld_size);

    lam_size_decode #(.MAX_LANES(MAX_LANES)) size_dec_i (
        .size_i (size_sel),
        .sel_o  (lane_sel)
    );

    lam_shift_merge #(
        .DST_W     (DST_W),
        .LANE_W    (LANE_W),
        .MAX_LANES (MAX_LANES)
    ) merge_i (
        .old_i    (dst_old),
        .src_i    (ld_data),
        .sel_i    (lane_sel),
        .merged_o (merged)
    );

    always_comb begin
        st_d = st_q;
        if (ld_valid) st_d.dst = merged;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dst_new = st_q.dst;

    // decoder must select exactly one width
    a_r3_one_lane: assert property (@(posedge clk) disable iff (rst)
        $countones(lane_sel) == 1);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> dst_new == '0);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |=> $stable(dst_new));

    a_r3_byte_merge: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_size) |=>
            dst_new == {$past(ld_data[LANE_W-1:0]), $past(dst_old[DST_W-1:LANE_W])});

    a_r4_half_merge: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_size) |=>
            dst_new == {$past(ld_data[2*LANE_W-1:0]), $past(dst_old[DST_W-1:2*LANE_W])});
endmodule

// File: tb/load_align_merge_tb.sv
module load_align_merge_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        ld_valid;
    logic        ld_size;
    logic [15:0] ld_data;
    logic [63:0] dst_old;
    logic [63:0] dst_new;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    load_align_merge dut_i (
        .clk      (clk),
        .rst      (rst),
        .ld_valid (ld_valid),
        .ld_size  (ld_size),
        .ld_data  (ld_data),
        .dst_old  (dst_old),
        .dst_new  (dst_new)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // apply one load for one edge; returns with result visible
    task automatic do_load(logic [63:0] old, logic sz, logic [15:0] data);
        @(negedge clk);
        dst_old = old; ld_size = sz; ld_data = data; ld_valid = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; ld_valid = 1'b0; ld_size = 1'b0; ld_data = '0; dst_old = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 reset value", dst_new, 64'h0);
        do_load(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 16'h1234);
        // reset together with a load: reset wins
        @(negedge clk);
        rst = 1'b1; ld_valid = 1'b1; ld_data = 16'hAAAA;
        @(negedge clk);
        rst = 1'b0; ld_valid = 1'b0;
        check("R1 reset over load", dst_new, 64'h0);
    endtask

    task automatic t_byte;
        do_load(64'h1122_3344_5566_7788, 1'b0, 16'hAB99);
        check("R3 byte merge", dst_new, 64'h9911_2233_4455_6677);
    endtask

    task automatic t_half;
        do_load(64'h1122_3344_5566_7788, 1'b1, 16'hCDAB);
        check("R4 half merge", dst_new, 64'hCDAB_1122_3344_5566);
    endtask

    task automatic t_upper_ignored;
        do_load(64'h0, 1'b0, 16'hFF42);
        check("R5 upper byte ignored a", dst_new, 64'h4200_0000_0000_0000);
        do_load(64'h0, 1'b0, 16'h0042);
        check("R5 upper byte ignored b", dst_new, 64'h4200_0000_0000_0000);
    endtask

    task automatic t_endian;
        do_load(64'h0, 1'b1, 16'h0201);
        check("R6 lane order", dst_new, 64'h0201_0000_0000_0000);
    endtask

    task automatic t_hold;
        do_load(64'h0, 1'b1, 16'h5A5A);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            dst_old = {4{16'(i * 16'h1111)}}; ld_data = 16'hFFFF; ld_size = i[0];
        end
        check("R2 hold while idle", dst_new, 64'h5A5A_0000_0000_0000);
    endtask

    task automatic t_byte_chain;
        logic [63:0] v = 64'hFFFF_FFFF_FFFF_FFFF;
        for (int i = 1; i <= 4; i++) begin
            do_load(v, 1'b0, 16'(i));
            v = dst_new;
        end
        check("R7 byte chain", v, 64'h0403_0201_FFFF_FFFF);
    endtask

    task automatic t_half_chain;
        logic [63:0] v = 64'hFFFF_FFFF_FFFF_FFFF;
        for (int i = 0; i < 4; i++) begin
            do_load(v, 1'b1, {8'(2 * i + 2), 8'(2 * i + 1)});
            v = dst_new;
        end
        check("R8 half chain", v, 64'h0807_0605_0403_0201);
    endtask

    task automatic t_raw_bits;
        do_load(64'h0, 1'b0, 16'h0080);
        check("R9 no sign extension", dst_new, 64'h8000_0000_0000_0000);
        do_load(64'h0000_0000_0000_00FF, 1'b0, 16'h0000);
        check("R9 low byte discarded", dst_new, 64'h0);
        do_load(64'h0000_0000_0000_FFFF, 1'b1, 16'h8000);
        check("R9 low half discarded", dst_new, 64'h8000_0000_0000_0000);
    endtask

    initial begin
        t_reset();
        t_byte();
        t_half();
        t_upper_ignored();
        t_endian();
        t_hold();
        t_byte_chain();
        t_half_chain();
        t_raw_bits();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule